// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This block settles conditional branches for a small 16-bit RISC pipeline. A flag-setting operation (a compare, done as a true subtraction, or an add) runs on two operands. It produces four flags: zero, negative, carry and overflow. These flags are captured in a register and kept until the next flag-setting operation.

A later branch presents a 4-bit condition code, the current PC and an 8-bit signed displacement. The unit evaluates the condition against the stored flags and reports whether the branch is taken. It also produces the next PC, which is either the branch target or the sequential address.

A compare is always evaluated as a + ~b + 1, so the carry is the no-borrow carry-out. Signed conditions are derived from negative and overflow rather than from a negated second operand. This keeps a second operand of 0x8000 and a second operand of zero correct.

Top module: `cmp_branch_unit`

## Requirements
- R1: With op_sel = 0 (compare), the unit computes a + ~b + 1 on 16 bits. flag_z is set exactly when that result is zero, and flag_n equals its bit 15.
- R2: On a compare, flag_c is the carry-out of a + ~b + 1. It is therefore 1 whenever a >= b unsigned, including every compare against zero and every compare of equal operands.
- R3: flag_v is set when the compare or add overflows as signed 16-bit arithmetic. For a compare this means the true difference a - b lies outside -32768..32767; for an add, the true sum a + b does.
- R4: With op_sel = 1 (add), the flags come from a + b. flag_c is the carry-out of that sum, so an add of zero always leaves flag_c = 0.
- R5: The flags load only at a rising clock edge where alu_en is 1. Otherwise they hold, whatever the operands do. All four flags are 0 out of reset.
- R6: Signed condition codes: 3 = less (n^v), 4 = greater-or-equal, 5 = less-or-equal, 6 = greater. These match a signed comparison of the last compared operands, including b = 0x8000.
- R7: Unsigned condition codes: 7 = lower (carry clear), 8 = higher-or-same (carry set), 9 = lower-or-same, 10 = higher. These match an unsigned comparison of the last compared operands.
- R8: Code 0 is always taken, 1 is equal (zero flag set), 2 is not-equal. Codes 11 to 15 are never taken.
- R9: When br_en is 1 and the condition holds, br_taken is 1 and next_pc = pc + 2*sign_extend(disp) + 2, modulo 2^16.
- R10: When br_en is 0 or the condition fails, br_taken is 0 and next_pc = pc + 2, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_en | input | 1 | Load the flags from this cycle's operation |
| op_sel | input | 1 | 0 = compare (subtract), 1 = add |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| br_en | input | 1 | A branch is being resolved this cycle |
| cond | input | 4 | Branch condition code |
| pc | input | 16 | Address of the branch |
| disp | input | 8 | Signed displacement in instruction units |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry (no-borrow) flag |
| flag_v | output | 1 | Stored signed overflow flag |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 16 | Address of the next instruction |

## Verification
The hardest cases to reach are the operand pairs where a naive negate-and-add gives a wrong answer. These are b = 0x8000 with signed conditions, and b = 0 with unsigned conditions. They only show up when a stored flag set meets the right condition code. The stimulus therefore compares every pair drawn from 0x0000, 0x0001, 0x0002, 0x7FFF, 0x8000 and 0xFFFF. After each compare it resolves all sixteen condition codes on consecutive cycles, while scrambling the operand inputs with alu_en low. This exercises both the corner arithmetic and the holding of the flags.

// File: rtl/cbu_pkg.sv
`timescale 1ns/1ps
package cbu_pkg;

  localparam logic OP_SUB = 1'b0;
  localparam logic OP_ADD = 1'b1;

  localparam logic [3:0] CC_AL  = 4'd0;
  localparam logic [3:0] CC_EQ  = 4'd1;
  localparam logic [3:0] CC_NE  = 4'd2;
  localparam logic [3:0] CC_LT  = 4'd3;
  localparam logic [3:0] CC_GE  = 4'd4;
  localparam logic [3:0] CC_LE  = 4'd5;
  localparam logic [3:0] CC_GT  = 4'd6;
  localparam logic [3:0] CC_LTU = 4'd7;
  localparam logic [3:0] CC_GEU = 4'd8;
  localparam logic [3:0] CC_LEU = 4'd9;
  localparam logic [3:0] CC_GTU = 4'd10;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cbu_flags_t;

endpackage

// File: rtl/cbu_flag_alu.sv
`timescale 1ns/1ps
module cbu_flag_alu
  import cbu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         op_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cbu_flags_t   flags_out
);

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   sum_ext;
  logic [W-1:0] sum;

  // compare is a true subtraction: a + ~b + 1
  always_comb begin
    b_eff = (op_sel == OP_SUB) ? ~b : b;
    cin   = (op_sel == OP_SUB);
    sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = sum_ext[W-1:0];
  end

  always_comb begin
    flags_out.n = sum[W-1];
    flags_out.z = (sum == '0);
    flags_out.c = sum_ext[W];
    flags_out.v = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end

endmodule

// File: rtl/cbu_flag_reg.sv
`timescale 1ns/1ps
module cbu_flag_reg
  import cbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  cbu_flags_t d,
  output cbu_flags_t q
);

  cbu_flags_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R5: flags hold without a load
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));

  // R5: flags take the computed value on a load
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q == $past(d)));

endmodule

// File: rtl/cbu_cond_eval.sv
`timescale 1ns/1ps
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  logic [3:0] cond,
  input  cbu_flags_t flags,
  output logic       cond_true
);

  logic s_lt;
  logic u_lt;

  always_comb begin
    s_lt = flags.n ^ flags.v;
    u_lt = !flags.c;
    case (cond)
      CC_AL:   cond_true = 1'b1;
      CC_EQ:   cond_true = flags.z;
      CC_NE:   cond_true = !flags.z;
      CC_LT:   cond_true = s_lt;
      CC_GE:   cond_true = !s_lt;
      CC_LE:   cond_true = s_lt || flags.z;
      CC_GT:   cond_true = !s_lt && !flags.z;
      CC_LTU:  cond_true = u_lt;
      CC_GEU:  cond_true = !u_lt;
      CC_LEU:  cond_true = u_lt || flags.z;
      CC_GTU:  cond_true = !u_lt && !flags.z;
      default: cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbu_pc_target.sv
`timescale 1ns/1ps
module cbu_pc_target #(
  parameter int W          = 16,
  parameter int DW         = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic [W-1:0]  pc,
  input  logic [DW-1:0] disp,
  input  logic          taken,
  output logic [W-1:0]  next_pc
);

  localparam int           SHIFT = $clog2(INSN_BYTES);
  localparam logic [W-1:0] STEP  = W'(INSN_BYTES);

  logic [W-1:0] disp_ext;
  logic [W-1:0] offs;
  logic [W-1:0] seq_pc;

  always_comb begin
    disp_ext = {{(W-DW){disp[DW-1]}}, disp};
    offs     = disp_ext << SHIFT;
    seq_pc   = pc + STEP;
    next_pc  = taken ? (seq_pc + offs) : seq_pc;
  end

endmodule

// File: rtl/cmp_branch_unit.sv
`timescale 1ns/1ps
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int W          = 16,
  parameter int DW         = 8,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alu_en,
  input  logic          op_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          br_en,
  input  logic [3:0]    cond,
  input  logic [W-1:0]  pc,
  input  logic [DW-1:0] disp,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          br_taken,
  output logic [W-1:0]  next_pc
);

  localparam logic [W-1:0] STEP    = W'(INSN_BYTES);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic [1:0] rst_sync_nxt;
  logic       rst_sync_n;

  always_comb rst_sync_nxt = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= rst_sync_nxt;
  end

  assign rst_sync_n = rst_sync_q[1];

  cbu_flags_t flags_calc;
  cbu_flags_t flags_q;
  logic       cond_true;

  cbu_flag_alu #(.W(W)) alu_i (
    .op_sel    (op_sel),
    .a         (opnd_a),
    .b         (opnd_b),
    .flags_out (flags_calc)
  );

  cbu_flag_reg flags_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (alu_en),
    .d       (flags_calc),
    .q       (flags_q)
  );

  cbu_cond_eval cond_i (
    .cond      (cond),
    .flags     (flags_q),
    .cond_true (cond_true)
  );

  assign br_taken = br_en && cond_true;

  cbu_pc_target #(.W(W), .DW(DW), .INSN_BYTES(INSN_BYTES)) tgt_i (
    .pc      (pc),
    .disp    (disp),
    .taken   (br_taken),
    .next_pc (next_pc)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // R2: compare against zero leaves carry set
  a_r2_cmp_zero_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_en && op_sel == OP_SUB && opnd_b == '0) |=> flag_c);

  // R2: equal operands give zero with carry set
  a_r2_equal_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_en && op_sel == OP_SUB && opnd_a == opnd_b) |=> (flag_z && flag_c));

  // R4: an add of zero never carries
  a_r4_add_zero_no_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_en && op_sel == OP_ADD && opnd_b == '0) |=> !flag_c);

  // R6: nothing is signed-less than the most negative value
  a_r6_min_operand: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alu_en && op_sel == OP_SUB && opnd_b == MIN_NEG) |=> (flag_n == flag_v));

  // R8: codes above 10 never branch
  a_r8_undef_not_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_en && cond > CC_GTU) |-> !br_taken);

  // R10: no branch request means sequential flow
  a_r10_idle_sequential: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !br_en |-> (!br_taken && next_pc == pc + STEP));

  // R9: a target stays on an instruction boundary relative to pc
  a_r9_target_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_taken |-> (next_pc[0] == pc[0]));

endmodule

// File: tb/cmp_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_en;
  logic        op_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic        br_en;
  logic [3:0]  cond;
  logic [15:0] pc;
  logic [7:0]  disp;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic        br_taken;
  logic [15:0] next_pc;

  always #5 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_en(br_en), .cond(cond),
    .pc(pc), .disp(disp), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .br_taken(br_taken), .next_pc(next_pc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_en = 1'b0;

  // scoreboard queues
  logic [3:0]  q_flags[$];
  string       q_ftag[$];
  logic        q_taken[$];
  logic [15:0] q_npc[$];
  string       q_ttag[$];

  logic [3:0] model_flags;  // {n,z,c,v} of the last flag-setting op

  function automatic logic [3:0] ref_sub(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    int d;
    s = {1'b0, a} + {1'b0, ~b} + 17'd1;
    d = int'($signed(a)) - int'($signed(b));
    return {s[15], s[15:0] == 16'd0, s[16], (d > 32767 || d < -32768)};
  endfunction

  function automatic logic [3:0] ref_add(logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    int d;
    s = {1'b0, a} + {1'b0, b};
    d = int'($signed(a)) + int'($signed(b));
    return {s[15], s[15:0] == 16'd0, s[16], (d > 32767 || d < -32768)};
  endfunction

  // direct comparison model, used after a compare
  function automatic logic ref_cmp_taken(logic [15:0] a, logic [15:0] b, logic [3:0] c);
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return a == b;
      4'd2:  return a != b;
      4'd3:  return $signed(a) <  $signed(b);
      4'd4:  return $signed(a) >= $signed(b);
      4'd5:  return $signed(a) <= $signed(b);
      4'd6:  return $signed(a) >  $signed(b);
      4'd7:  return a <  b;
      4'd8:  return a >= b;
      4'd9:  return a <= b;
      4'd10: return a >  b;
      default: return 1'b0;
    endcase
  endfunction

  // flag based model, used after an add
  function automatic logic ref_flag_taken(logic [3:0] f, logic [3:0] c);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return z;
      4'd2:  return !z;
      4'd3:  return n != v;
      4'd4:  return n == v;
      4'd5:  return (n != v) || z;
      4'd6:  return (n == v) && !z;
      4'd7:  return !cy;
      4'd8:  return cy;
      4'd9:  return !cy || z;
      4'd10: return cy && !z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] ref_npc(logic [15:0] p, logic [7:0] d, logic tk);
    int t;
    t = int'(p) + 2;
    if (tk) t = t + 2 * int'($signed(d));
    return t[15:0];
  endfunction

  function automatic string cond_tag(logic [3:0] c);
    if (c >= 4'd3 && c <= 4'd6) return "R6";
    if (c >= 4'd7 && c <= 4'd10) return "R7";
    return "R8";
  endfunction

  // driver tasks: called just after a rising edge, return just after one
  task automatic do_op(logic op, logic [15:0] a, logic [15:0] b);
    alu_en = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; br_en = 1'b0; mon_en = 1'b0;
    model_flags = op ? ref_add(a, b) : ref_sub(a, b);
    @(posedge clk); #1;
    alu_en = 1'b0;
  endtask

  task automatic do_branch(logic [3:0] c, logic [15:0] p, logic [7:0] d,
                           logic exp_tk, string ftag);
    // operands scrambled with alu_en low: flags must not move (R5)
    opnd_a = p ^ 16'h5A5A; opnd_b = ~p; op_sel = ~op_sel;
    br_en = 1'b1; cond = c; pc = p; disp = d; mon_en = 1'b1;
    q_flags.push_back(model_flags); q_ftag.push_back(ftag);
    q_taken.push_back(exp_tk); q_npc.push_back(ref_npc(p, d, exp_tk));
    q_ttag.push_back(exp_tk ? {cond_tag(c), " R9"} : {cond_tag(c), " R10"});
    @(posedge clk); #1;
    br_en = 1'b0; mon_en = 1'b0;
  endtask

  task automatic do_idle(logic [3:0] c, logic [15:0] p, logic [7:0] d);
    br_en = 1'b0; cond = c; pc = p; disp = d; mon_en = 1'b1;
    q_flags.push_back(model_flags); q_ftag.push_back("R5");
    q_taken.push_back(1'b0); q_npc.push_back(ref_npc(p, d, 1'b0));
    q_ttag.push_back("R10");
    @(posedge clk); #1;
    mon_en = 1'b0;
  endtask

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (q_flags.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 scoreboard empty actual=result expected=none");
      end else begin
        logic [3:0]  ef;
        logic        et;
        logic [15:0] ep;
        string       tf, tt;
        ef = q_flags.pop_front(); tf = q_ftag.pop_front();
        et = q_taken.pop_front(); ep = q_npc.pop_front(); tt = q_ttag.pop_front();
        checks++;
        if ({flag_n, flag_z, flag_c, flag_v} !== ef) begin
          fails++;
          $display("FAIL %s flags nzcv actual=%b expected=%b", tf,
                   {flag_n, flag_z, flag_c, flag_v}, ef);
        end
        checks++;
        if (br_taken !== et || next_pc !== ep) begin
          fails++;
          $display("FAIL %s cond=%0d taken/next_pc actual=%b/%h expected=%b/%h",
                   tt, cond, br_taken, next_pc, et, ep);
        end
      end
    end
  end

  logic [15:0] corner [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF};
  logic [7:0]  dsel   [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hC3};

  initial begin
    rst_n = 1'b0; alu_en = 1'b0; op_sel = 1'b0; opnd_a = '0; opnd_b = '0;
    br_en = 1'b0; cond = '0; pc = '0; disp = '0; model_flags = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({flag_n, flag_z, flag_c, flag_v} !== 4'b0000) begin
      fails++;
      $display("FAIL R5 reset flags actual=%b expected=0000",
               {flag_n, flag_z, flag_c, flag_v});
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // compares over all corner pairs, every condition code (R1 R2 R3 R6 R7 R8)
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        do_op(1'b0, corner[i], corner[j]);
        for (int c = 0; c < 16; c++) begin
          logic [15:0] p;
          p = 16'h1000 + 16'(i * 256 + j * 32 + c * 2);
          do_branch(4'(c), p, dsel[(i + j + c) % 6],
                    ref_cmp_taken(corner[i], corner[j], 4'(c)), "R1 R2 R3");
        end
      end
    end

    // adds (R4), conditions decided from the stored flags
    begin
      logic [15:0] aa [6] = '{16'h0002, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0000, 16'h1234};
      logic [15:0] bb [6] = '{16'h0000, 16'h0001, 16'h0001, 16'h8000, 16'h0000, 16'h4321};
      for (int k = 0; k < 6; k++) begin
        do_op(1'b1, aa[k], bb[k]);
        for (int c = 0; c < 11; c++)
          do_branch(4'(c), 16'h2000 + 16'(k * 64 + c * 2), dsel[(k + c) % 6],
                    ref_flag_taken(model_flags, 4'(c)), "R4");
      end
    end

    // sequential flow and wrap-around (R10, R9)
    do_op(1'b0, 16'h0005, 16'h0005);
    do_idle(4'd0, 16'hFFFE, 8'h7F);
    do_idle(4'd1, 16'h3000, 8'h80);
    do_branch(4'd0, 16'hFFFE, 8'h01, 1'b1, "R5");
    do_branch(4'd0, 16'h0000, 8'h80, 1'b1, "R5");
    do_branch(4'd2, 16'hFFFE, 8'h10, 1'b0, "R5");

    repeat (3) @(posedge clk);
    checks++;
    if (q_flags.size() != 0) begin
      fails++;
      $display("FAIL R9 scoreboard leftover actual=%0d expected=0", q_flags.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule